// File: doc/BRIEF.md
# Reset Cause Recorder and System Reset Merger

The block gathers seven independent reset requests (power-on, low-voltage, external pin, watchdog expiry, illegal opcode, illegal address and a debug-forced request) and turns them into one system reset. The reset asserts at once when any enabled request is present. It is released in step with the clock through a short synchronizer and then held for a programmable stretch. The external pin counts only while a software pin-enable input is high.

Alongside the reset, the block keeps a status byte that records which sources caused the most recent reset. A new reset sequence overwrites the causes of earlier sequences. Requests that arrive while one sequence is still running are added to it. Power-on takes precedence over every other source. A debug-forced reset leaves no trace in the byte. The byte can be read through a simple register port. A write to the same address leaves the byte untouched and instead produces a watchdog-service strobe for a neighbouring timer. The block also presents the fixed values a core needs on leaving reset: the two vector fetch addresses, the initial stack pointer and a set interrupt mask.

Top module: `rst_status_ctrl`

## Requirements
- R1: Any enabled request asserts `sys_rst_o` in the same cycle, with no clock edge needed.
- R2: After the last request drops, `sys_rst_o` stays high for exactly SYNC_STAGES + STRETCH_CYCLES rising edges and goes low after the last of them. With the default values this is 18 edges, which is at least 16 clock cycles.
- R3: `pin_rst_i` is a request only while `pin_rst_en_i` is 1. While the enable is 0, the pin neither asserts reset nor changes the status byte.
- R4: The status bit map is: bit0 power-on, bit1 low-voltage, bit2 pin, bit3 watchdog, bit4 illegal opcode, bit5 illegal address, and the remaining bits read 0. The first request of a new reset sequence, with `sys_rst_o` low in the previous cycle, replaces the whole byte.
- R5: A power-on request sets the byte to 0x03 (power-on and low-voltage bits only). Non-power-on requests later in the same sequence are not added.
- R6: Non-power-on requests that occur in the same cycle or in the same sequence all have their bits set together.
- R7: A debug-forced request asserts reset but has no status bit. A sequence started by debug alone leaves the byte at 0x00.
- R8: `rdata_o` equals the status byte when `rd_en_i` is 1 and `addr_i` equals STATUS_ADDR. Otherwise it is 0.
- R9: A write (`wr_en_i` with `addr_i` equal to STATUS_ADDR) leaves the status byte unchanged and raises `wdog_kick_o` in the same cycle.
- R10: `vec_hi_addr_o` is 0xFFFE, `vec_lo_addr_o` is 0xFFFF, `sp_init_o` is 0x00FF and `imask_init_o` is 1.
- R11: While `rst_ni` is low, the status byte is 0 and `sys_rst_o` is high. After `rst_ni` rises, the R2 stretch applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| por_i | input | 1 | Power-on detect request |
| lvd_i | input | 1 | Low-voltage detect request |
| pin_rst_i | input | 1 | External reset pin, active high |
| pin_rst_en_i | input | 1 | Enables the pin as a reset source |
| wdog_rst_i | input | 1 | Watchdog timeout request |
| ilop_rst_i | input | 1 | Illegal opcode strobe |
| ilad_rst_i | input | 1 | Illegal address strobe |
| dbg_rst_i | input | 1 | Debug-forced reset request |
| rd_en_i | input | 1 | Register read enable |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | ADDR_W | Register address |
| rdata_o | output | DATA_W | Read data |
| wdog_kick_o | output | 1 | Watchdog-service strobe on a status write |
| sys_rst_o | output | 1 | Stretched system reset |
| vec_hi_addr_o | output | 16 | Address of the start-vector high byte |
| vec_lo_addr_o | output | 16 | Address of the start-vector low byte |
| sp_init_o | output | 16 | Initial stack pointer |
| imask_init_o | output | 1 | Initial interrupt mask |

## Verification
The bench uses the default values: SYNC_STAGES 2, STRETCH_CYCLES 16, DATA_W 8, ADDR_W 4 and STATUS_ADDR 0. With these values the 18-edge release can be counted exactly, and a full reset sequence stays short enough to run many random single-source and paired-source sequences. The pairs are applied in the same cycle and in consecutive cycles, with the pin enable chosen at random. This covers power-on precedence, cause accumulation within a sequence and the debug-only case. Directed cases cover a gated pin, which must leave reset low and the byte unchanged, and a write to the status address.

// File: rtl/rst_status_pkg.sv
package rst_status_pkg;
  localparam int N_SRC = 7;
  // source index doubles as status bit position for the recorded ones
  localparam int SRC_POR  = 0;
  localparam int SRC_LVD  = 1;
  localparam int SRC_PIN  = 2;
  localparam int SRC_WDOG = 3;
  localparam int SRC_ILOP = 4;
  localparam int SRC_ILAD = 5;
  localparam int SRC_DBG  = 6;
  localparam int N_REC    = 6;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rst_req_sync.sv
module rst_req_sync #(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_any_i,
  output logic rst_o
);
  localparam int CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STRETCH_CYCLES);

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  // assert asynchronously on any request, release through the shift chain
  assign arst_n = rst_ni & ~req_any_i;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) sync_q <= '1;
    else         sync_q <= sync_q << 1;
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)                       cnt_q <= CNT_LOAD;
    else if (sync_q[SYNC_STAGES-1])    cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = ~arst_n | sync_q[SYNC_STAGES-1] | (cnt_q != '0);
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
  import rst_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_vec_t          req_i,
  input  logic              sys_rst_i,
  output logic [DATA_W-1:0] status_o
);
  logic              busy_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] new_bits;
  logic [DATA_W-1:0] por_bits;

  assign new_bits = DATA_W'(req_i[N_REC-1:0]);
  assign por_bits = DATA_W'((1 << SRC_POR) | (1 << SRC_LVD));

  // busy_q: reset was active in the previous cycle -> same sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b1;
    else         busy_q <= sys_rst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (req_i[SRC_POR]) begin
      status_q <= por_bits;
    end else if (req_i != '0) begin
      if (!busy_q)                    status_q <= new_bits;
      else if (!status_q[SRC_POR])    status_q <= status_q | new_bits;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl
  import rst_status_pkg::*;
#(
  parameter int              SYNC_STAGES    = 2,
  parameter int              STRETCH_CYCLES = 16,
  parameter int              DATA_W         = 8,
  parameter int              ADDR_W         = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR  = '0,
  parameter logic [15:0]     VEC_HI_ADDR    = 16'hFFFE,
  parameter logic [15:0]     SP_INIT        = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              lvd_i,
  input  logic              pin_rst_i,
  input  logic              pin_rst_en_i,
  input  logic              wdog_rst_i,
  input  logic              ilop_rst_i,
  input  logic              ilad_rst_i,
  input  logic              dbg_rst_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdog_kick_o,
  output logic              sys_rst_o,
  output logic [15:0]       vec_hi_addr_o,
  output logic [15:0]       vec_lo_addr_o,
  output logic [15:0]       sp_init_o,
  output logic              imask_init_o
);
  src_vec_t          req_vec;
  logic [DATA_W-1:0] status_q;
  logic              addr_hit;
  logic              wr_hit;

  always_comb begin
    req_vec           = '0;
    req_vec[SRC_POR]  = por_i;
    req_vec[SRC_LVD]  = lvd_i;
    req_vec[SRC_PIN]  = pin_rst_i & pin_rst_en_i;
    req_vec[SRC_WDOG] = wdog_rst_i;
    req_vec[SRC_ILOP] = ilop_rst_i;
    req_vec[SRC_ILAD] = ilad_rst_i;
    req_vec[SRC_DBG]  = dbg_rst_i;
  end

  rst_req_sync #(
    .SYNC_STAGES   (SYNC_STAGES),
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_any_i(|req_vec),
    .rst_o    (sys_rst_o)
  );

  rst_cause_rec #(
    .DATA_W(DATA_W)
  ) u_rec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_vec),
    .sys_rst_i(sys_rst_o),
    .status_o (status_q)
  );

  assign addr_hit    = (addr_i == STATUS_ADDR);
  assign wr_hit      = wr_en_i & addr_hit;
  assign rdata_o     = (rd_en_i && addr_hit) ? status_q : '0;
  assign wdog_kick_o = wr_hit;

  assign vec_hi_addr_o = VEC_HI_ADDR;
  assign vec_lo_addr_o = VEC_HI_ADDR + 16'd1;
  assign sp_init_o     = SP_INIT;
  assign imask_init_o  = 1'b1;
endmodule

// File: rtl/rst_status_chk.sv
module rst_status_chk
  import rst_status_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int STRETCH_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input src_vec_t          gated_i,
  input logic              pin_raw_i,
  input logic              pin_en_i,
  input logic              sys_rst_i,
  input logic [DATA_W-1:0] status_i,
  input logic              wr_hit_i
);
  localparam int QW = $clog2(STRETCH_CYCLES + 8) + 1;

  logic [QW-1:0] quiet_q;
  logic          prev_rst_q;
  src_vec_t      others;

  always_comb begin
    others          = gated_i;
    others[SRC_PIN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           quiet_q <= '0;
    else if (gated_i != '0)                quiet_q <= '0;
    else if (sys_rst_i && quiet_q != '1)   quiet_q <= quiet_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_rst_q <= 1'b1;
    else         prev_rst_q <= sys_rst_i;
  end

  a_r1_req_forces_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_i != '0) |-> sys_rst_i);

  a_r2_min_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_i) |-> (quiet_q >= QW'(STRETCH_CYCLES)));

  a_r3_pin_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_rst_q && pin_raw_i && !pin_en_i && others == '0) |-> !sys_rst_i);

  a_r5_por_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_i[SRC_POR] |=> (status_i == DATA_W'(3)));

  a_r5_por_implies_lvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[SRC_POR] |-> status_i[SRC_LVD]);

  a_r6_fresh_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_rst_q && gated_i != '0 && !gated_i[SRC_POR])
      |=> (status_i == DATA_W'($past(gated_i[N_REC-1:0]))));

  a_r7_dbg_no_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_rst_q && gated_i == src_vec_t'(1 << SRC_DBG)) |=> (status_i == '0));

  a_r9_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && gated_i == '0) |=> $stable(status_i));
endmodule

bind rst_status_ctrl rst_status_chk #(
  .DATA_W        (DATA_W),
  .STRETCH_CYCLES(STRETCH_CYCLES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gated_i  (req_vec),
  .pin_raw_i(pin_rst_i),
  .pin_en_i (pin_rst_en_i),
  .sys_rst_i(sys_rst_o),
  .status_i (status_q),
  .wr_hit_i (wr_hit)
);

// File: tb/sim_rst_status_ctrl.sv
`timescale 1ns/1ps
module sim_rst_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req = '0;  // 0 por,1 lvd,2 pin,3 wdog,4 ilop,5 ilad,6 dbg
  logic       pin_en = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] rdata;
  logic       kick, sys_rst, imask;
  logic [15:0] vhi, vlo, sp;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model = '0;

  always #5 clk = ~clk;

  rst_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .por_i(req[0]), .lvd_i(req[1]), .pin_rst_i(req[2]), .pin_rst_en_i(pin_en),
    .wdog_rst_i(req[3]), .ilop_rst_i(req[4]), .ilad_rst_i(req[5]), .dbg_rst_i(req[6]),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .rdata_o(rdata),
    .wdog_kick_o(kick), .sys_rst_o(sys_rst),
    .vec_hi_addr_o(vhi), .vec_lo_addr_o(vlo), .sp_init_o(sp), .imask_init_o(imask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] gate(input logic [6:0] v, input logic en);
    logic [6:0] g = v;
    if (!en) g[2] = 1'b0;
    return g;
  endfunction

  // expected status after a sequence made of v1 then v2 starting from idle
  function automatic logic [7:0] expect_status(input logic [7:0] prev, input logic [6:0] v1,
                                               input logic [6:0] v2, input logic en);
    logic [6:0] g = gate(v1, en) | gate(v2, en);
    if (g == '0)  return prev;
    if (g[0])     return 8'h03;
    return {2'b00, g[5:0]};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!sys_rst) return;
      @(negedge clk);
    end
  endtask

  task automatic read_status(output logic [7:0] v);
    rd_en = 1'b1; addr = 4'd0;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_seq(input logic [6:0] v1, input logic [6:0] v2, input logic en, input string tag);
    logic [7:0] got;
    wait_idle();
    pin_en = en;
    req = v1;
    @(negedge clk);
    req = v2;
    @(negedge clk);
    req = '0;
    @(negedge clk);
    wait_idle();
    model = expect_status(model, v1, v2, en);
    read_status(got);
    check(tag, {24'd0, got}, {24'd0, model});
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'd20240611));
    // R11 reset state
    #12;
    check("R11 sys_rst in reset", {31'd0, sys_rst}, 32'd1);
    rd_en = 1'b1; #1 check("R11 status cleared", {24'd0, rdata}, 32'd0); rd_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (17) @(negedge clk);
    check("R11 stretch after rst_ni edge17", {31'd0, sys_rst}, 32'd1);
    @(negedge clk);
    check("R11 released edge18", {31'd0, sys_rst}, 32'd0);

    // R10 constants
    check("R10 vec hi", {16'd0, vhi}, 32'hFFFE);
    check("R10 vec lo", {16'd0, vlo}, 32'hFFFF);
    check("R10 sp", {16'd0, sp}, 32'h00FF);
    check("R10 imask", {31'd0, imask}, 32'd1);

    // R1 + R2 watchdog single cycle
    req = 7'h08;
    #1 check("R1 immediate assert", {31'd0, sys_rst}, 32'd1);
    @(negedge clk); req = '0;
    repeat (17) @(negedge clk);
    check("R2 still held edge17", {31'd0, sys_rst}, 32'd1);
    @(negedge clk);
    check("R2 released edge18", {31'd0, sys_rst}, 32'd0);
    model = 8'h08;
    read_status(got);
    check("R4 watchdog bit3", {24'd0, got}, 32'h08);

    // R3 gated pin
    pin_en = 1'b0; req = 7'h04;
    #1 check("R3 gated pin no reset", {31'd0, sys_rst}, 32'd0);
    repeat (3) @(negedge clk);
    check("R3 gated pin stays low", {31'd0, sys_rst}, 32'd0);
    req = '0;
    read_status(got);
    check("R3 status untouched", {24'd0, got}, {24'd0, model});

    // R3 enabled pin
    run_seq(7'h04, 7'h00, 1'b1, "R3 enabled pin");
    // R5 por priority then later ilop ignored
    run_seq(7'h01, 7'h10, 1'b1, "R5 por then ilop");
    // R4 fresh replaces por record
    run_seq(7'h20, 7'h00, 1'b0, "R4 ilad replaces");
    // R6 same cycle and consecutive
    run_seq(7'h18, 7'h00, 1'b0, "R6 same cycle wdog+ilop");
    run_seq(7'h02, 7'h24, 1'b1, "R6 lvd then pin+ilad");
    // R7 debug only
    run_seq(7'h40, 7'h00, 1'b0, "R7 debug only");
    run_seq(7'h40, 7'h08, 1'b0, "R7 debug then wdog");

    // R8 read decode
    rd_en = 1'b0; addr = 4'd0;
    #1 check("R8 no rd_en", {24'd0, rdata}, 32'd0);
    rd_en = 1'b1; addr = 4'd5;
    #1 check("R8 wrong addr", {24'd0, rdata}, 32'd0);
    rd_en = 1'b0; addr = 4'd0;
    @(negedge clk);

    // R9 write inert, kick strobe
    wr_en = 1'b1; addr = 4'd0;
    #1 check("R9 kick", {31'd0, kick}, 32'd1);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R9 kick drops", {31'd0, kick}, 32'd0);
    read_status(got);
    check("R9 status after write", {24'd0, got}, {24'd0, model});

    // random single sources and pairs
    for (int k = 0; k < 80; k++) begin
      logic [6:0] a, b;
      logic e;
      a = 7'(1 << ($urandom % 7));
      b = ($urandom % 2) ? 7'(1 << ($urandom % 7)) : 7'h00;
      if ($urandom % 3 == 0) a = a | b;
      e = 1'($urandom % 2);
      run_seq(a, b, e, "R4 R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule